// File: doc/BRIEF.md
# Operand-Ready Dispatch Scheduler

This block is the waiting room between instruction rename and the execution units of an out-of-order core. Each micro-operation it accepts names two source tags, one destination tag, the execution port it must run on and an age tag that encodes program order. A source is either marked ready when the operation arrives or becomes ready later, when a completion bus broadcasts a matching result tag.

Every cycle, the scheduler runs one independent selection per execution port. The candidates for a port are the held operations that have both sources ready and that target that port. When the port reports that it can take work, the oldest candidate is presented on that port's issue lane. It is removed from the station at the next clock edge. A flush request, carrying an age tag, discards every held operation that is strictly younger than that tag. This is used to squash the wrong path after a mispredicted branch.

The station holds eight operations and drives five issue lanes by default. Insertion takes at most one operation per cycle. The upstream stage must hold its request while `in_ready` is low.

Top module: `rs_dispatch_sched`

## Requirements
- R1: An operation offered with `in_valid` high while `in_ready` is high is stored. `in_ready` is low exactly when all ENTRIES slots are occupied at the start of the cycle, and an offer made while it is low is ignored.
- R2: A held operation is issued only when both of its source ready bits are set.
- R3: A completion broadcast (`wb_valid[b]` high with `wb_tag[b]`) sets the ready bit of every held source whose tag matches. An operation inserted in the same cycle as a matching broadcast stores that source as ready. Readiness gained at a clock edge can be selected in the following cycle.
- R4: No operation is issued on port p during a cycle in which `port_free[p]` is low. The operation stays held and competes again later.
- R5: Each port issues at most one operation per cycle, and different ports issue in parallel in the same cycle. `in_port` holds a port number in the range 0 to PORTS-1.
- R6: Among the ready operations that target the same free port, the oldest one issues. Operation A is older than B when the most significant bit of (A.age − B.age), taken modulo 2^AGE_W, is 1. The ages held at any time are distinct and span less than half the age range.
- R7: An operation issued in a cycle leaves the station at that cycle's closing edge, and its slot can be reused from the next cycle on. Operations targeting the same port therefore issue one after another in age order.
- R8: While `flush_valid` is high, every held operation strictly younger than `flush_age` is not issued in that cycle and is removed at the closing edge. Operations whose age is equal to or older than `flush_age` are kept. An offer accepted in the same cycle with an age younger than `flush_age` is dropped.
- R9: After reset the station is empty: `in_ready` is high and no `iss_valid` bit is set.
- R10: An issue lane carries the destination and both source tags of the operation selected for that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Offer of a new operation |
| in_ready | output | 1 | A slot is free, so the offer is taken |
| in_src0 | input | TAG_W | First source tag |
| in_src0_rdy | input | 1 | First source already available |
| in_src1 | input | TAG_W | Second source tag |
| in_src1_rdy | input | 1 | Second source already available |
| in_dst | input | TAG_W | Destination tag |
| in_port | input | PORT_W | Execution port the operation needs |
| in_age | input | AGE_W | Program-order age tag |
| wb_valid | input | WB_N | Completion bus strobes |
| wb_tag | input | WB_N x TAG_W | Completed result tags |
| flush_valid | input | 1 | Discard operations younger than flush_age |
| flush_age | input | AGE_W | Age boundary of the flush |
| port_free | input | PORTS | Port can accept an operation this cycle |
| iss_valid | output | PORTS | Lane carries an issued operation |
| iss_dst | output | PORTS x TAG_W | Destination tag per lane |
| iss_src0 | output | PORTS x TAG_W | First source tag per lane |
| iss_src1 | output | PORTS x TAG_W | Second source tag per lane |

## Verification
A lost wakeup shows as an operation that never reaches its lane. A spurious ready bit makes an operation appear on a lane in the cycle after insertion, while its source is still pending. Both are visible within one cycle of the broadcast, or of the insertion. A wrong age comparison or a stale slot puts the wrong destination tag on a lane, or lets one operation appear twice, in the very cycle the selection is made. A corrupted occupancy bit shows up on `in_ready` in the first cycle it flips. The bench keeps its own model of the held operations and compares every lane and `in_ready` on every cycle, so any divergence is reported in the cycle it first becomes visible.

// File: rtl/rs_pkg.sv
// rs_pkg: shared age-tag type and ordering helper for the dispatch scheduler.
// Assumes the ages in flight span less than half of the age range.
package rs_pkg;
    parameter int AGE_W = 6;
    typedef logic [AGE_W-1:0] age_t;

    // True when age a is earlier in program order than age b (wrap-aware).
    function automatic logic age_before(input age_t a, input age_t b);
        age_t diff;
        diff = a - b;
        return diff[AGE_W-1];
    endfunction
endpackage

// File: rtl/rs_entry.sv
// rs_entry: one scheduler slot. It holds an operation's tags, port and age,
// and keeps its two source ready bits up to date by snooping the completion
// buses, including the broadcast seen in the cycle the slot is written.
// Assumes the top writes (alloc_i) only into a free slot, and asserts
// issue_i only while the slot is ready.
module rs_entry
    import rs_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int PORT_W = 3,
    parameter int WB_N   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_i,
    input  logic [TAG_W-1:0]             src0_i,
    input  logic                         rdy0_i,
    input  logic [TAG_W-1:0]             src1_i,
    input  logic                         rdy1_i,
    input  logic [TAG_W-1:0]             dst_i,
    input  logic [PORT_W-1:0]            port_i,
    input  age_t                         age_i,
    input  logic [WB_N-1:0]              wb_valid_i,
    input  logic [WB_N-1:0][TAG_W-1:0]   wb_tag_i,
    input  logic                         flush_i,
    input  age_t                         flush_age_i,
    input  logic                         issue_i,
    output logic                         busy_o,
    output logic                         ready_o,
    output logic                         kill_o,
    output logic [PORT_W-1:0]            port_o,
    output age_t                         age_o,
    output logic [TAG_W-1:0]             dst_o,
    output logic [TAG_W-1:0]             src0_o,
    output logic [TAG_W-1:0]             src1_o
);
    logic              busy_q, rdy0_q, rdy1_q;
    logic [TAG_W-1:0]  src0_q, src1_q, dst_q;
    logic [PORT_W-1:0] port_q;
    age_t              age_q;
    logic              hit0, hit1, hit0_in, hit1_in;

    // Compare every completion tag with the held and the incoming sources.
    always_comb begin
        hit0 = 1'b0; hit1 = 1'b0; hit0_in = 1'b0; hit1_in = 1'b0;
        for (int b = 0; b < WB_N; b++) begin
            if (wb_valid_i[b]) begin
                if (wb_tag_i[b] == src0_q) hit0    = 1'b1;
                if (wb_tag_i[b] == src1_q) hit1    = 1'b1;
                if (wb_tag_i[b] == src0_i) hit0_in = 1'b1;
                if (wb_tag_i[b] == src1_i) hit1_in = 1'b1;
            end
        end
    end

    // The slot is squashed when a flush names an older boundary.
    assign kill_o  = busy_q && flush_i && age_before(flush_age_i, age_q);
    assign ready_o = rdy0_q && rdy1_q;
    assign busy_o  = busy_q;
    assign port_o  = port_q;
    assign age_o   = age_q;
    assign dst_o   = dst_q;
    assign src0_o  = src0_q;
    assign src1_o  = src1_q;

    // Slot state: load on allocation, otherwise wake up, issue or squash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            rdy0_q <= 1'b0;
            rdy1_q <= 1'b0;
            src0_q <= '0;
            src1_q <= '0;
            dst_q  <= '0;
            port_q <= '0;
            age_q  <= '0;
        end else if (alloc_i) begin
            busy_q <= 1'b1;
            rdy0_q <= rdy0_i | hit0_in;
            rdy1_q <= rdy1_i | hit1_in;
            src0_q <= src0_i;
            src1_q <= src1_i;
            dst_q  <= dst_i;
            port_q <= port_i;
            age_q  <= age_i;
        end else begin
            if (issue_i || kill_o) busy_q <= 1'b0;
            rdy0_q <= rdy0_q | hit0;
            rdy1_q <= rdy1_q | hit1;
        end
    end

    AST_ALLOC_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n) alloc_i |-> !busy_q); // R1
    AST_ISSUE_NEEDS_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n) issue_i |-> (busy_q && rdy0_q && rdy1_q)); // R2
    AST_WAKE_SRC0: assert property (@(posedge clk) disable iff (!rst_n) (busy_q && hit0 && !issue_i && !kill_o) |=> rdy0_q); // R3
    AST_WAKE_SRC1: assert property (@(posedge clk) disable iff (!rst_n) (busy_q && hit1 && !issue_i && !kill_o) |=> rdy1_q); // R3
    AST_ISSUE_LEAVES: assert property (@(posedge clk) disable iff (!rst_n) issue_i |=> !busy_q); // R7
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) kill_o |=> !busy_q); // R8
    AST_NO_ISSUE_WHEN_KILLED: assert property (@(posedge clk) disable iff (!rst_n) !(issue_i && kill_o)); // R8
endmodule

// File: rtl/rs_port_sel.sv
// rs_port_sel: oldest-first picker for one execution port. A requester wins
// when no other requester is older; nothing wins while the port is busy.
// Assumes the ages of the requesters are distinct.
module rs_port_sel
    import rs_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ENTRIES-1:0]         req_i,
    input  logic [ENTRIES-1:0][AGE_W-1:0] age_i,
    input  logic                       free_i,
    output logic [ENTRIES-1:0]         grant_o
);
    // Pairwise age comparison among the requesters.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            grant_o[i] = req_i[i] && free_i;
            for (int j = 0; j < ENTRIES; j++) begin
                if (j != i && req_i[j] && age_before(age_i[j], age_i[i])) grant_o[i] = 1'b0;
            end
        end
    end

    AST_ONE_GRANT_PER_PORT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant_o)); // R5
    AST_BUSY_PORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !free_i |-> (grant_o == '0)); // R4

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_win
        for (genvar gj = 0; gj < ENTRIES; gj++) begin : g_vs
            if (gi != gj) begin : g_pair
                AST_OLDEST_WINS: assert property (@(posedge clk) disable iff (!rst_n) (grant_o[gi] && req_i[gj]) |-> age_before(age_i[gi], age_i[gj])); // R6
            end
        end
    end
endmodule

// File: rtl/rs_dispatch_sched.sv
// rs_dispatch_sched: reservation-station scheduler. It writes each accepted
// operation into the lowest free slot, runs one oldest-first picker per
// execution port over the slots that are ready and not being flushed, drives
// the issue lanes combinationally and frees the issued slots at the edge.
// Assumes in_port < PORTS, and in-flight ages that are distinct and span
// less than half the age range.
module rs_dispatch_sched
    import rs_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PORTS   = 5,
    parameter int TAG_W   = 6,
    parameter int WB_N    = 2,
    localparam int PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [TAG_W-1:0]            in_src0,
    input  logic                        in_src0_rdy,
    input  logic [TAG_W-1:0]            in_src1,
    input  logic                        in_src1_rdy,
    input  logic [TAG_W-1:0]            in_dst,
    input  logic [PORT_W-1:0]           in_port,
    input  logic [AGE_W-1:0]            in_age,
    input  logic [WB_N-1:0]             wb_valid,
    input  logic [WB_N-1:0][TAG_W-1:0]  wb_tag,
    input  logic                        flush_valid,
    input  logic [AGE_W-1:0]            flush_age,
    input  logic [PORTS-1:0]            port_free,
    output logic [PORTS-1:0]            iss_valid,
    output logic [PORTS-1:0][TAG_W-1:0] iss_dst,
    output logic [PORTS-1:0][TAG_W-1:0] iss_src0,
    output logic [PORTS-1:0][TAG_W-1:0] iss_src1
);
    logic [ENTRIES-1:0]               busy, ready, kill, alloc, issue;
    logic [ENTRIES-1:0][PORT_W-1:0]   ent_port;
    logic [ENTRIES-1:0][AGE_W-1:0]    ent_age;
    logic [ENTRIES-1:0][TAG_W-1:0]    ent_dst, ent_src0, ent_src1;
    logic [PORTS-1:0][ENTRIES-1:0]    req, grant;
    logic                             in_keep, found;

    // Accept when a slot is free; drop an offer that the same flush squashes.
    assign in_ready = ~&busy;
    assign in_keep  = in_valid && in_ready && !(flush_valid && age_before(flush_age, in_age));

    // Steer the accepted operation into the lowest-numbered free slot.
    always_comb begin
        alloc = '0;
        found = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!busy[i] && !found) begin
                alloc[i] = in_keep;
                found    = 1'b1;
            end
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        rs_entry #(.TAG_W(TAG_W), .PORT_W(PORT_W), .WB_N(WB_N)) u_slot (
            .clk(clk), .rst_n(rst_n), .alloc_i(alloc[e]),
            .src0_i(in_src0), .rdy0_i(in_src0_rdy),
            .src1_i(in_src1), .rdy1_i(in_src1_rdy),
            .dst_i(in_dst), .port_i(in_port), .age_i(in_age),
            .wb_valid_i(wb_valid), .wb_tag_i(wb_tag),
            .flush_i(flush_valid), .flush_age_i(flush_age),
            .issue_i(issue[e]),
            .busy_o(busy[e]), .ready_o(ready[e]), .kill_o(kill[e]),
            .port_o(ent_port[e]), .age_o(ent_age[e]), .dst_o(ent_dst[e]),
            .src0_o(ent_src0[e]), .src1_o(ent_src1[e])
        );
    end

    // Candidates per port: held, both operands ready, not being squashed.
    always_comb begin
        for (int p = 0; p < PORTS; p++) begin
            for (int i = 0; i < ENTRIES; i++) begin
                req[p][i] = busy[i] && ready[i] && !kill[i] && (ent_port[i] == PORT_W'(p));
            end
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        rs_port_sel #(.ENTRIES(ENTRIES)) u_sel (
            .clk(clk), .rst_n(rst_n), .req_i(req[p]), .age_i(ent_age),
            .free_i(port_free[p]), .grant_o(grant[p])
        );
    end

    // Fold the grants into per-slot removal and per-lane issue fields.
    always_comb begin
        issue = '0;
        for (int p = 0; p < PORTS; p++) begin
            iss_valid[p] = |grant[p];
            iss_dst[p]   = '0;
            iss_src0[p]  = '0;
            iss_src1[p]  = '0;
            for (int i = 0; i < ENTRIES; i++) begin
                if (grant[p][i]) begin
                    issue[i]    = 1'b1;
                    iss_dst[p]  = iss_dst[p]  | ent_dst[i];
                    iss_src0[p] = iss_src0[p] | ent_src0[i];
                    iss_src1[p] = iss_src1[p] | ent_src1[i];
                end
            end
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
        logic [PORTS-1:0] col;
        for (genvar p = 0; p < PORTS; p++) begin : g_col
            assign col[p] = grant[p][e];
        end
        AST_SLOT_ON_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(col)); // R5
    end
    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !in_ready) |-> (alloc == '0)); // R1
endmodule

// File: tb/sim_rs_dispatch_sched.sv
// sim_rs_dispatch_sched: directed cases and a long random sweep, checked
// every cycle against a behavioural model of the held operations.
module sim_rs_dispatch_sched;
    localparam int N = 8, P = 5, TW = 6, WB = 2, PW = 3, AW = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, in_valid, in_ready, in_src0_rdy, in_src1_rdy, flush_valid;
    logic [TW-1:0] in_src0, in_src1, in_dst;
    logic [PW-1:0] in_port;
    logic [AW-1:0] in_age, flush_age;
    logic [WB-1:0] wb_valid;
    logic [WB-1:0][TW-1:0] wb_tag;
    logic [P-1:0] port_free, iss_valid;
    logic [P-1:0][TW-1:0] iss_dst, iss_src0, iss_src1;

    rs_dispatch_sched #(.ENTRIES(N), .PORTS(P), .TAG_W(TW), .WB_N(WB)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_src0(in_src0), .in_src0_rdy(in_src0_rdy), .in_src1(in_src1),
        .in_src1_rdy(in_src1_rdy), .in_dst(in_dst), .in_port(in_port),
        .in_age(in_age), .wb_valid(wb_valid), .wb_tag(wb_tag),
        .flush_valid(flush_valid), .flush_age(flush_age), .port_free(port_free),
        .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_src0(iss_src0), .iss_src1(iss_src1)
    );

    int n_chk = 0, n_fail = 0;
    logic          m_busy [N];
    logic          m_r0 [N], m_r1 [N];
    logic [TW-1:0] m_s0 [N], m_s1 [N], m_dst [N];
    logic [PW-1:0] m_port [N];
    logic [AW-1:0] m_age [N];
    int            g_best [P];
    logic [AW-1:0] seq = '0;

    function automatic logic b_older(input logic [AW-1:0] a, input logic [AW-1:0] b);
        logic [AW-1:0] d;
        d = a - b;
        return d[AW-1];
    endfunction

    function automatic logic m_kill(input int i);
        return m_busy[i] && flush_valid && b_older(flush_age, m_age[i]);
    endfunction

    function automatic logic m_anyfree();
        for (int i = 0; i < N; i++) if (!m_busy[i]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Settle, then compare in_ready and every lane with the model.
    task automatic look(input string lbl);
        logic af;
        #2;
        af = m_anyfree();
        chk(in_ready == af, {lbl, " R1 in_ready"}, in_ready, af);
        for (int p = 0; p < P; p++) begin
            int best;
            best = -1;
            for (int i = 0; i < N; i++) begin
                if (m_busy[i] && !m_kill(i) && m_r0[i] && m_r1[i] && m_port[i] == PW'(p) && port_free[p]) begin
                    if (best < 0 || b_older(m_age[i], m_age[best])) best = i;
                end
            end
            g_best[p] = best;
            chk(iss_valid[p] == (best >= 0), {lbl, " R2 R4 R5 R6 lane valid"}, iss_valid[p], best >= 0);
            if (best >= 0) begin
                chk(iss_dst[p] == m_dst[best], {lbl, " R10 dst"}, iss_dst[p], m_dst[best]);
                chk(iss_src0[p] == m_s0[best], {lbl, " R10 src0"}, iss_src0[p], m_s0[best]);
                chk(iss_src1[p] == m_s1[best], {lbl, " R10 src1"}, iss_src1[p], m_s1[best]);
            end
        end
    endtask

    // Cross the clock edge and apply the same edge to the model.
    task automatic adv();
        logic ins, keep, k [N];
        ins  = in_valid && m_anyfree();
        keep = ins && !(flush_valid && b_older(flush_age, in_age));
        for (int i = 0; i < N; i++) k[i] = m_kill(i);
        @(posedge clk);
        for (int p = 0; p < P; p++) if (g_best[p] >= 0) m_busy[g_best[p]] = 1'b0;
        for (int i = 0; i < N; i++) if (k[i]) m_busy[i] = 1'b0;
        for (int i = 0; i < N; i++) begin
            for (int b = 0; b < WB; b++) begin
                if (wb_valid[b] && wb_tag[b] == m_s0[i]) m_r0[i] = 1'b1;
                if (wb_valid[b] && wb_tag[b] == m_s1[i]) m_r1[i] = 1'b1;
            end
        end
        if (keep) begin
            int slot;
            slot = -1;
            for (int i = 0; i < N; i++) if (!m_busy[i] && slot < 0) slot = i;
            m_busy[slot] = 1'b1; m_s0[slot] = in_src0; m_s1[slot] = in_src1;
            m_dst[slot] = in_dst; m_port[slot] = in_port; m_age[slot] = in_age;
            m_r0[slot] = in_src0_rdy; m_r1[slot] = in_src1_rdy;
            for (int b = 0; b < WB; b++) begin
                if (wb_valid[b] && wb_tag[b] == in_src0) m_r0[slot] = 1'b1;
                if (wb_valid[b] && wb_tag[b] == in_src1) m_r1[slot] = 1'b1;
            end
        end
        if (ins) seq = seq + 1'b1;
        #1;
    endtask

    task automatic idle();
        in_valid = 0; wb_valid = '0; flush_valid = 0; port_free = '1;
    endtask

    task automatic offer(input int s0, input logic r0, input int s1, input logic r1, input int d, input int pt);
        in_valid = 1; in_src0 = TW'(s0); in_src0_rdy = r0; in_src1 = TW'(s1);
        in_src1_rdy = r1; in_dst = TW'(d); in_port = PW'(pt); in_age = seq;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_busy[i] = 0; m_r0[i] = 0; m_r1[i] = 0; m_s0[i] = '0; m_s1[i] = '0;
            m_dst[i] = '0; m_port[i] = '0; m_age[i] = '0;
        end
        rst_n = 0; idle(); in_src0 = '0; in_src1 = '0; in_dst = '0; in_port = '0;
        in_src0_rdy = 0; in_src1_rdy = 0; in_age = '0; flush_age = '0; wb_tag = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R9: empty after reset
        look("reset");
        chk(in_ready == 1'b1, "R9 in_ready after reset", in_ready, 1);
        chk(iss_valid == '0, "R9 no issue after reset", iss_valid, 0);
        adv();

        // R1: fill all slots with waiting ops on port 0, then offer one more
        for (int k = 0; k < N; k++) begin
            offer(1, 0, 1, 0, 10 + k, 0);
            look("fill");
            adv();
        end
        offer(2, 1, 2, 1, 63, 0);
        look("full");
        chk(in_ready == 1'b0, "R1 full station stalls", in_ready, 0);
        adv();
        idle();

        // R8: flush at age 4 drops ages 5..7, keeps 0..4
        flush_valid = 1; flush_age = 6'd4;
        look("flush");
        adv();
        idle();
        look("after flush");
        chk(in_ready == 1'b1, "R8 flush frees younger slots", in_ready, 1);
        adv();

        // R3: broadcast tag 1 wakes every held op
        wb_valid[0] = 1; wb_tag[0] = 6'd1;
        look("wake");
        adv();
        idle();
        look("oldest");
        chk(iss_valid[0] && iss_dst[0] == 6'd10, "R6 oldest issues first", iss_dst[0], 10);
        adv();
        port_free[0] = 0;
        look("port busy");
        chk(iss_valid[0] == 1'b0, "R4 busy port gets nothing", iss_valid[0], 0);
        adv();
        idle();
        for (int k = 1; k < 5; k++) begin
            look("drain");
            chk(iss_valid[0] && iss_dst[0] == TW'(10 + k), "R7 removed in age order", iss_dst[0], 10 + k);
            adv();
        end
        look("empty port 0");
        chk(iss_valid[0] == 1'b0, "R8 flushed ops never issue", iss_valid[0], 0);
        adv();

        // R3: same-cycle wakeup of an incoming op
        offer(9, 0, 3, 1, 40, 2);
        wb_valid[1] = 1; wb_tag[1] = 6'd9;
        look("same-cycle wake");
        adv();
        idle();
        look("same-cycle wake issue");
        chk(iss_valid[2] && iss_dst[2] == 6'd40, "R3 same-cycle wakeup", iss_dst[2], 40);
        adv();

        // R5: five ready ops on five ports issue together
        for (int k = 0; k < P; k++) begin
            offer(0, 1, 0, 1, 20 + k, k);
            port_free = '0;
            look("load lanes");
            adv();
        end
        idle();
        look("parallel");
        chk($countones(iss_valid) == P, "R5 all lanes in one cycle", $countones(iss_valid), P);
        adv();

        // Random sweep checked against the model
        for (int c = 0; c < 4000; c++) begin
            logic hold;
            idle();
            hold = 0;
            for (int i = 0; i < N; i++) if (m_busy[i] && AW'(seq - m_age[i]) >= 20) hold = 1;
            if (!hold && $urandom_range(0, 2) != 0)
                offer($urandom_range(0, 7), 1'($urandom_range(0, 1)), $urandom_range(0, 7),
                      1'($urandom_range(0, 1)), $urandom_range(0, 63), $urandom_range(0, P - 1));
            port_free = P'($urandom);
            wb_valid = WB'($urandom);
            wb_tag[0] = TW'($urandom_range(0, 7));
            wb_tag[1] = TW'($urandom_range(0, 7));
            if ($urandom_range(0, 19) == 0) begin
                flush_valid = 1;
                flush_age = seq - AW'($urandom_range(1, 10));
            end
            look("random");
            adv();
        end
        idle();
        finish_run();
    end
endmodule